// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block turns a request naming one of eight 16-bit pointer registers into a 23-bit data address. The upper 7 address bits come from a page input and the lower 16 bits from the pointer. The address is always the pointer value before the update. In the same clock edge the block writes the updated pointer back into its own pointer file. A request also carries an update kind and an access width. The update kind is one of: no change, post-increment, post-decrement, or indexed by pointer 0. The access width is one or two words, and it sets the increment and decrement step.

Each pointer can run linear or circular, chosen by its own bit of a circular-enable vector. In circular mode an update stays inside a buffer that starts at a start register and spans a size register. Pointer pairs share one start register, and groups of four pointers share one size register. When an update leaves the buffer, the size is subtracted or added to bring it back. A separate load port lets the surrounding core write any pointer directly.

Top module: `circ_agen`

## Requirements
- R1: After a synchronous active-high reset, `addr_valid` and `addr_out` are 0 and every pointer holds 0.
- R2: A request accepted on a clock edge gives `addr_valid`=1 and `addr_out` = {`page`, selected pointer before modification} after that edge. `addr_valid` is 0 after any edge without a request.
- R3: Update kind 0 (`req_kind`=2'b00) leaves the selected pointer unchanged.
- R4: Update kind 1 (2'b01) is post-increment. It adds 1 when `req_wide`=0 and 2 when `req_wide`=1, modulo 2^16, when the pointer is linear.
- R5: Update kind 2 (2'b10) is post-decrement. It subtracts 1 or 2 by the same width rule, modulo 2^16, when the pointer is linear.
- R6: Update kind 3 (2'b11) writes the selected pointer plus pointer 0 back into the selected pointer. Indexing pointer 0 doubles it.
- R7: Bit i of `circ_en` makes pointer i circular. Pointer i uses start field `buf_start[(i/2)*16 +: 16]` and size field `buf_size[(i/4)*16 +: 16]`. When the bit is 0, updates are linear.
- R8: A circular increment or indexed update whose result reaches start+size or beyond has size subtracted from it.
- R9: A circular decrement whose result falls below start has size added to it.
- R10: The written-back pointer is seen by a request in the very next cycle.
- R11: `ptr_wr_en` writes `ptr_wr_data` into pointer `ptr_wr_sel` on the clock edge. It takes priority over a same-cycle update of the same pointer. An update of a different pointer in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr_en | input | 1 | Direct pointer load strobe |
| ptr_wr_sel | input | 3 | Pointer to load |
| ptr_wr_data | input | 16 | Value to load |
| page | input | 7 | Upper address field |
| circ_en | input | 8 | Per-pointer circular enable |
| buf_start | input | 64 | Four buffer start fields, one per pointer pair |
| buf_size | input | 32 | Two buffer size fields, one per group of four |
| req_valid | input | 1 | Address request |
| req_sel | input | 3 | Pointer used by the request |
| req_kind | input | 2 | Update kind: 0 none, 1 inc, 2 dec, 3 indexed |
| req_wide | input | 1 | 0 one-word access, 1 two-word access |
| addr_valid | output | 1 | Registered address strobe |
| addr_out | output | 23 | Registered effective address |

## Verification
The bench builds the block with its default parameters: eight pointers of 16 bits and a 7-bit page. With these values the pointer start and size field offsets (i/2 and i/4) are exercised across different pairs and groups. The 16-bit modulo wrap at 0xFFFF and 0x0000 is reached with a single step. Buffers of size 5 and 3 make both circular wrap directions appear within a few requests. These include an indexed wrap and a pointer in a circular group whose own enable bit is clear.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'b00,
    UPD_INC  = 2'b01,
    UPD_DEC  = 2'b10,
    UPD_IDX  = 2'b11
  } upd_kind_e;
endpackage

// File: rtl/agen_ptr_file.sv
module agen_ptr_file #(
  parameter int N_PTR = 8,
  parameter int PTR_W = 16,
  localparam int IDX_W = $clog2(N_PTR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_sel,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_sel,
  input  logic [PTR_W-1:0] up_val,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [PTR_W-1:0] rd_val,
  output logic [PTR_W-1:0] base_val
);
  logic [PTR_W-1:0] regs [N_PTR];

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (ld_en && ld_sel == IDX_W'(g))
        regs[g] <= ld_val;
      else if (up_en && up_sel == IDX_W'(g))
        regs[g] <= up_val;
    end
  end

  assign rd_val   = regs[rd_sel];
  assign base_val = regs[0];
endmodule

// File: rtl/agen_bank_sel.sv
module agen_bank_sel #(
  parameter int N_PTR = 8,
  parameter int PTR_W = 16,
  localparam int IDX_W   = $clog2(N_PTR),
  localparam int N_START = N_PTR / 2,
  localparam int N_SIZE  = N_PTR / 4
) (
  input  logic [IDX_W-1:0]         sel,
  input  logic [N_START*PTR_W-1:0] starts,
  input  logic [N_SIZE*PTR_W-1:0]  sizes,
  output logic [PTR_W-1:0]         start_o,
  output logic [PTR_W-1:0]         size_o
);
  always_comb begin
    start_o = starts[(int'(sel) / 2) * PTR_W +: PTR_W];
    size_o  = sizes[(int'(sel) / 4) * PTR_W +: PTR_W];
  end
endmodule

// File: rtl/agen_next_calc.sv
module agen_next_calc
  import agen_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  upd_kind_e        kind,
  input  logic             wide,
  input  logic             circ,
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] index,
  input  logic [PTR_W-1:0] start,
  input  logic [PTR_W-1:0] size,
  output logic [PTR_W-1:0] nxt
);
  logic [PTR_W:0] mag, up_sum, dn_sum, limit, floor_chk;

  always_comb begin
    mag       = (kind == UPD_IDX) ? {1'b0, index} : (wide ? (PTR_W+1)'(2) : (PTR_W+1)'(1));
    up_sum    = {1'b0, cur} + mag;
    dn_sum    = {1'b0, cur} - mag;
    limit     = {1'b0, start} + {1'b0, size};
    floor_chk = {1'b0, start} + mag;
    nxt       = cur;
    unique case (kind)
      UPD_NONE: nxt = cur;
      UPD_INC, UPD_IDX: begin
        if (circ && up_sum >= limit) nxt = PTR_W'(up_sum - {1'b0, size});
        else                         nxt = PTR_W'(up_sum);
      end
      UPD_DEC: begin
        if (circ && {1'b0, cur} < floor_chk) nxt = PTR_W'(dn_sum + {1'b0, size});
        else                                 nxt = PTR_W'(dn_sum);
      end
    endcase
  end
endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import agen_pkg::*;
#(
  parameter int N_PTR  = 8,
  parameter int PTR_W  = 16,
  parameter int PAGE_W = 7,
  localparam int IDX_W  = $clog2(N_PTR),
  localparam int ADDR_W = PAGE_W + PTR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ptr_wr_en,
  input  logic [IDX_W-1:0]           ptr_wr_sel,
  input  logic [PTR_W-1:0]           ptr_wr_data,
  input  logic [PAGE_W-1:0]          page,
  input  logic [N_PTR-1:0]           circ_en,
  input  logic [(N_PTR/2)*PTR_W-1:0] buf_start,
  input  logic [(N_PTR/4)*PTR_W-1:0] buf_size,
  input  logic                       req_valid,
  input  logic [IDX_W-1:0]           req_sel,
  input  logic [1:0]                 req_kind,
  input  logic                       req_wide,
  output logic                       addr_valid,
  output logic [ADDR_W-1:0]          addr_out
);
  upd_kind_e        kind;
  logic [PTR_W-1:0] cur_ptr, base_ptr, cur_start, cur_size, upd_next;
  logic             cur_circ, upd_en;

  assign kind     = upd_kind_e'(req_kind);
  assign cur_circ = circ_en[req_sel];
  assign upd_en   = req_valid && (kind != UPD_NONE);

  agen_ptr_file #(.N_PTR(N_PTR), .PTR_W(PTR_W)) u_file (
    .clk(clk), .rst(rst),
    .ld_en(ptr_wr_en), .ld_sel(ptr_wr_sel), .ld_val(ptr_wr_data),
    .up_en(upd_en), .up_sel(req_sel), .up_val(upd_next),
    .rd_sel(req_sel), .rd_val(cur_ptr), .base_val(base_ptr)
  );

  agen_bank_sel #(.N_PTR(N_PTR), .PTR_W(PTR_W)) u_bank (
    .sel(req_sel), .starts(buf_start), .sizes(buf_size),
    .start_o(cur_start), .size_o(cur_size)
  );

  agen_next_calc #(.PTR_W(PTR_W)) u_calc (
    .kind(kind), .wide(req_wide), .circ(cur_circ), .cur(cur_ptr),
    .index(base_ptr), .start(cur_start), .size(cur_size), .nxt(upd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= {page, cur_ptr};
    end
  end
endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int N_PTR  = 8,
  parameter int PTR_W  = 16,
  parameter int PAGE_W = 7,
  localparam int IDX_W  = $clog2(N_PTR),
  localparam int ADDR_W = PAGE_W + PTR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ptr_wr_en,
  input logic [PAGE_W-1:0] page,
  input logic [N_PTR-1:0]  circ_en,
  input logic              req_valid,
  input logic [IDX_W-1:0]  req_sel,
  input logic [1:0]        req_kind,
  input logic              req_wide,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr_out,
  input logic              cur_circ,
  input logic [PTR_W-1:0]  cur_ptr,
  input logic [PTR_W-1:0]  cur_start,
  input logic [PTR_W-1:0]  cur_size,
  input logic [PTR_W-1:0]  upd_next
);
  logic cur_in, nxt_in;
  assign cur_in = ({1'b0, cur_ptr} >= {1'b0, cur_start}) &&
                  ({1'b0, cur_ptr} < {1'b0, cur_start} + {1'b0, cur_size});
  assign nxt_in = ({1'b0, upd_next} >= {1'b0, cur_start}) &&
                  ({1'b0, upd_next} < {1'b0, cur_start} + {1'b0, cur_size});

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid); // R2
  AST_VALID_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid); // R2
  AST_PAGE_FIELD: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_out[ADDR_W-1:PTR_W] == $past(page)); // R2
  AST_HOLD_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_kind) == 2'b00 && !$past(ptr_wr_en) &&
     req_valid && req_sel == $past(req_sel))
    |=> addr_out[PTR_W-1:0] == $past(addr_out[PTR_W-1:0])); // R3
  AST_LINEAR_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_kind) == 2'b01 && !$past(ptr_wr_en) &&
     !$past(cur_circ) && req_valid && req_sel == $past(req_sel))
    |=> addr_out[PTR_W-1:0] ==
        $past(addr_out[PTR_W-1:0]) + ($past(req_wide, 2) ? PTR_W'(2) : PTR_W'(1))); // R4
  AST_CIRC_STAYS_IN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_circ && (req_kind == 2'b01 || req_kind == 2'b10) &&
     cur_size >= PTR_W'(2) && cur_in) |-> nxt_in); // R8
endmodule

bind circ_agen circ_agen_chk #(.N_PTR(N_PTR), .PTR_W(PTR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst(rst), .ptr_wr_en(ptr_wr_en), .page(page), .circ_en(circ_en),
  .req_valid(req_valid), .req_sel(req_sel), .req_kind(req_kind), .req_wide(req_wide),
  .addr_valid(addr_valid), .addr_out(addr_out), .cur_circ(cur_circ), .cur_ptr(cur_ptr),
  .cur_start(cur_start), .cur_size(cur_size), .upd_next(upd_next)
);

// File: tb/circ_agen_tb_top.sv
module circ_agen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_wr_en = 1'b0;
  logic [2:0]  ptr_wr_sel = '0;
  logic [15:0] ptr_wr_data = '0;
  logic [6:0]  page = '0;
  logic [7:0]  circ_en = '0;
  logic [63:0] buf_start = '0;
  logic [31:0] buf_size = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [1:0]  req_kind = '0;
  logic        req_wide = 1'b0;
  logic        addr_valid;
  logic [22:0] addr_out;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_agen dut_i (
    .clk(clk), .rst(rst), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
    .ptr_wr_data(ptr_wr_data), .page(page), .circ_en(circ_en),
    .buf_start(buf_start), .buf_size(buf_size), .req_valid(req_valid),
    .req_sel(req_sel), .req_kind(req_kind), .req_wide(req_wide),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with req dropped
  task automatic issue(input logic [2:0] s, input logic [1:0] k, input logic w);
    req_valid = 1'b1; req_sel = s; req_kind = k; req_wide = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(input logic [2:0] s, input logic [15:0] v);
    ptr_wr_en = 1'b1; ptr_wr_sel = s; ptr_wr_data = v;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 addr_valid after reset", 32'(addr_valid), 32'd0);
    chk("R1 addr_out after reset", 32'(addr_out), 32'd0);
    page = 7'h11;
    for (int i = 0; i < 8; i++) begin
      issue(3'(i), 2'b00, 1'b0);
      chk("R1 pointer zero after reset", 32'(addr_out), {9'd0, 7'h11, 16'h0000});
    end
    @(negedge clk);
    chk("R2 addr_valid low when idle", 32'(addr_valid), 32'd0);
  endtask

  task automatic t_hold_page();
    load(3'd3, 16'h1234);
    page = 7'h5A;
    issue(3'd3, 2'b00, 1'b1);
    chk("R2 addr with page", 32'(addr_out), {9'd0, 7'h5A, 16'h1234});
    chk("R2 addr_valid after request", 32'(addr_valid), 32'd1);
    issue(3'd3, 2'b00, 1'b0);
    chk("R3 hold leaves pointer", 32'(addr_out[15:0]), 32'h1234);
    page = 7'h00;
  endtask

  task automatic t_linear_inc();
    load(3'd1, 16'hFFFF);
    issue(3'd1, 2'b01, 1'b0);
    chk("R4 pre-mod address", 32'(addr_out[15:0]), 32'hFFFF);
    issue(3'd1, 2'b01, 1'b1);
    chk("R4 narrow inc wraps 16 bits", 32'(addr_out[15:0]), 32'h0000);
    issue(3'd1, 2'b00, 1'b0);
    chk("R4 wide inc adds two", 32'(addr_out[15:0]), 32'h0002);
  endtask

  task automatic t_linear_dec();
    load(3'd2, 16'h0001);
    issue(3'd2, 2'b10, 1'b1);
    issue(3'd2, 2'b10, 1'b0);
    chk("R5 wide dec wraps 16 bits", 32'(addr_out[15:0]), 32'hFFFF);
    issue(3'd2, 2'b00, 1'b0);
    chk("R5 narrow dec subtracts one", 32'(addr_out[15:0]), 32'hFFFE);
  endtask

  task automatic t_indexed();
    load(3'd0, 16'h0010);
    load(3'd5, 16'h0100);
    issue(3'd5, 2'b11, 1'b0);
    chk("R6 indexed pre-mod", 32'(addr_out[15:0]), 32'h0100);
    issue(3'd5, 2'b00, 1'b0);
    chk("R6 indexed adds pointer 0", 32'(addr_out[15:0]), 32'h0110);
    issue(3'd0, 2'b11, 1'b0);
    issue(3'd0, 2'b00, 1'b0);
    chk("R6 indexing pointer 0 doubles it", 32'(addr_out[15:0]), 32'h0020);
  endtask

  task automatic t_circular();
    // pair 3 start at bits 63:48, group 1 size at bits 31:16
    buf_start = {16'h0200, 16'h0300, 16'h0500, 16'h0040};
    buf_size  = {16'h0005, 16'h0003};
    circ_en   = 8'b0101_0010;
    load(3'd6, 16'h0203);
    issue(3'd6, 2'b01, 1'b1);
    chk("R8 circ pre-mod", 32'(addr_out[15:0]), 32'h0203);
    issue(3'd6, 2'b10, 1'b0);
    chk("R8 circ inc wraps to start", 32'(addr_out[15:0]), 32'h0200);
    issue(3'd6, 2'b00, 1'b0);
    chk("R9 circ dec wraps to end", 32'(addr_out[15:0]), 32'h0204);
    load(3'd7, 16'h0204);
    issue(3'd7, 2'b01, 1'b0);
    issue(3'd7, 2'b00, 1'b0);
    chk("R7 clear enable bit stays linear", 32'(addr_out[15:0]), 32'h0205);
    load(3'd1, 16'h0042);
    issue(3'd1, 2'b01, 1'b0);
    issue(3'd1, 2'b00, 1'b0);
    chk("R7 pointer 1 uses pair 0 and group 0", 32'(addr_out[15:0]), 32'h0040);
    load(3'd0, 16'h0002);
    load(3'd4, 16'h0303);
    issue(3'd4, 2'b11, 1'b0);
    issue(3'd4, 2'b00, 1'b0);
    chk("R8 circ indexed wraps", 32'(addr_out[15:0]), 32'h0300);
    circ_en = '0;
  endtask

  task automatic t_priority();
    load(3'd3, 16'h0700);
    load(3'd2, 16'h0050);
    ptr_wr_en = 1'b1; ptr_wr_sel = 3'd3; ptr_wr_data = 16'hAAAA;
    issue(3'd3, 2'b01, 1'b0);
    ptr_wr_en = 1'b0;
    chk("R11 request sees old value", 32'(addr_out[15:0]), 32'h0700);
    issue(3'd3, 2'b00, 1'b0);
    chk("R11 load beats update", 32'(addr_out[15:0]), 32'hAAAA);
    ptr_wr_en = 1'b1; ptr_wr_sel = 3'd2; ptr_wr_data = 16'h1111;
    issue(3'd3, 2'b10, 1'b1);
    ptr_wr_en = 1'b0;
    issue(3'd3, 2'b00, 1'b0);
    chk("R11 other pointer update proceeds", 32'(addr_out[15:0]), 32'hAAA8);
    issue(3'd2, 2'b00, 1'b0);
    chk("R11 load to other pointer lands", 32'(addr_out[15:0]), 32'h1111);
  endtask

  task automatic t_back_to_back();
    load(3'd6, 16'h0010);
    issue(3'd6, 2'b01, 1'b0);
    issue(3'd6, 2'b01, 1'b0);
    chk("R10 next-cycle request sees update", 32'(addr_out[15:0]), 32'h0011);
    issue(3'd6, 2'b01, 1'b0);
    chk("R10 chained update", 32'(addr_out[15:0]), 32'h0012);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold_page();
    t_linear_inc();
    t_linear_dec();
    t_indexed();
    t_circular();
    t_priority();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule